// File: doc/BRIEF.md
# Prescaled Low-Frequency Tick Counter

This block is a free-running 24-bit up-counter for a 32.768 kHz clock domain. A 12-bit reload divider sets how often the count advances. The count moves once every (divider value + 1) clock cycles, so the increment rate is 32768/(divider+1) Hz. Four single-cycle command pulses control it: start, stop, clear, and a test command that jumps the count to 0xFFFFF0 so that a wrap can be reached quickly.

On every increment the block emits a one-cycle tick pulse. When the count rolls from all ones back to zero it also emits a one-cycle wrap pulse. The current count and a raw increment strobe are brought out for compare logic further downstream. The raw strobe also marks the one final increment that a stop can still let through.

The divider value is written through a plain write strobe. The write is accepted only while the counter is stopped. The running divider picks up the written value only when a start, clear or force-wrap command reloads it. All logic runs in the low-frequency clock domain.

Top module: `lf_tick_counter`

## Requirements
- R1: After reset the counter is stopped, count_o is 0, and tick_o, step_o and wrap_o are low. The divider value is 0, so a start with no divider write advances the count on every cycle.
- R2: With divider value D, the first increment after the start edge appears D+1 cycles later. Each further increment follows D+1 cycles after the previous one, and the divider is reloaded from the written value each time it runs out.
- R3: Each increment shows on count_o as old count + 1. In the same cycle, step_o is high for exactly one cycle, and tick_o is also high unless a stop is being asserted.
- R4: An increment from 0xFFFFFF gives count 0, and wrap_o pulses in the same cycle as tick_o.
- R5: force_wrap_i loads 0xFFFFF0 into the count with no tick, reloads the divider, and leaves the run state unchanged.
- R6: clear_i sets the count to 0 with no tick and reloads the divider. When clear_i and force_wrap_i arrive in the same cycle, the clear takes effect.
- R7: A divider write while running has no effect. A divider write while stopped is stored and used from the next start, clear or force-wrap onward.
- R8: From the cycle stop_i is asserted, tick_o and wrap_o stay low. If that cycle was due to increment, the count still advances once, shown by step_o.
- R9: When start_i and stop_i arrive in the same cycle, the counter ends up stopped.
- R10: While stopped, the count holds unless a clear or force-wrap command changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| clear_i | input | 1 | Clear-to-zero command pulse |
| force_wrap_i | input | 1 | Command pulse loading the near-wrap test value |
| div_wr_i | input | 1 | Divider write strobe |
| div_wdata_i | input | 12 | Divider value to write |
| count_o | output | 24 | Current count |
| step_o | output | 1 | Raw increment strobe, high in the cycle count_o shows a new incremented value |
| tick_o | output | 1 | Tick event pulse |
| wrap_o | output | 1 | Wrap event pulse |

## Verification
The hardest case to reach from the ports is a stop that lands exactly on the cycle in which the count rolls from all ones to zero. In that case the count must still advance, but both event pulses must stay silent. The stimulus reaches this case with a zero divider written while stopped and a force-wrap to 0xFFFFF0. A start then walks the count to all ones in fifteen predictable cycles, and the stop is issued on the cycle whose edge performs the roll-over. A separate pass with a divider of 2 crosses the wrap at the slower rate, which checks the reload spacing across the boundary.

// File: rtl/lftc_pkg.sv
// Package: shared decoded-command type for the prescaled tick counter.
// Assumes all consumers run in the same low-frequency clock domain.
package lftc_pkg;

    // Resolved command set after priority rules have been applied.
    typedef struct packed {
        logic run_set;    // enter running state
        logic run_clr;    // leave running state
        logic zero_cnt;   // force count to zero
        logic load_high;  // force count to near-wrap value
        logic reload;     // restart divider from programmed value
    } lftc_ctl_t;

endpackage

// File: rtl/lftc_task_ctl.sv
// Module: command resolver and run-state holder.
// Applies the priorities (stop over start, clear over force-wrap), keeps the
// running flag and tells the event path whether events may be emitted.
// Assumes the command inputs are single-cycle pulses synchronous to clk.
module lftc_task_ctl
    import lftc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      clear_i,
    input  logic      force_wrap_i,
    output lftc_ctl_t ctl_o,
    output logic      run_o,
    output logic      evt_ok_o
);

    logic run_q;

    // Resolve simultaneous commands into one consistent action set.
    always_comb begin
        ctl_o.run_clr   = stop_i;
        ctl_o.run_set   = start_i && !stop_i;
        ctl_o.zero_cnt  = clear_i;
        ctl_o.load_high = force_wrap_i && !clear_i;
        ctl_o.reload    = (start_i && !stop_i) || clear_i || force_wrap_i;
    end

    // Hold the running flag; stop takes priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= 1'b0;
        else if (ctl_o.run_clr)  run_q <= 1'b0;
        else if (ctl_o.run_set)  run_q <= 1'b1;
    end

    assign run_o    = run_q;
    assign evt_ok_o = run_q && !stop_i;

    // R9: a start colliding with a stop leaves the counter stopped
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i) |=> !run_q);

    // R9 / R1: a lone start always leads to the running state
    a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> run_q);

endmodule

// File: rtl/lftc_prescaler.sv
// Module: programmable reload divider.
// Holds the programmed divider value (writable only while stopped) and a
// shadow down-counter that is reloaded on command or when it runs out.
// Emits step_o in every running cycle in which the shadow count is zero.
module lftc_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             reload_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    output logic             step_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] shadow_q;

    // Accept a new divider value only while the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                  div_q <= '0;
        else if (div_wr_i && !run_i) div_q <= div_wdata_i;
    end

    // Count the shadow down; reload on command or when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               shadow_q <= '0;
        else if (reload_i)        shadow_q <= div_q;
        else if (run_i) begin
            if (shadow_q == '0)   shadow_q <= div_q;
            else                  shadow_q <= shadow_q - DIV_W'(1);
        end
    end

    assign step_o = run_i && (shadow_q == '0);

    // R7: divider writes while running leave the stored value untouched
    a_r7_locked_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && div_wr_i) |=> $stable(div_q));

    // R2: after a step the shadow restarts from the programmed value
    a_r2_reload_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !reload_i) |=> (shadow_q == $past(div_q)));

    // R10: the shadow never moves while stopped and not commanded
    a_r10_shadow_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> $stable(shadow_q));

endmodule

// File: rtl/lftc_count_core.sv
// Module: count register and event pulse generator.
// Clear beats force-wrap and both beat a pending increment. Event pulses are
// registered so they coincide with the new count value on count_o.
module lftc_count_core
    import lftc_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter logic [CNT_W-1:0] FORCE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lftc_ctl_t        ctl_i,
    input  logic             step_i,
    input  logic             evt_ok_i,
    output logic [CNT_W-1:0] count_o,
    output logic             step_o,
    output logic             tick_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] count_q;
    logic             inc_now;
    logic             at_top;

    // Decide whether this cycle performs an increment.
    always_comb begin
        inc_now = step_i && !ctl_i.zero_cnt && !ctl_i.load_high;
        at_top  = (count_q == '1);
    end

    // Update the count by command priority, then by increment.
    always_ff @(posedge clk) begin
        if (!rst_n)               count_q <= '0;
        else if (ctl_i.zero_cnt)  count_q <= '0;
        else if (ctl_i.load_high) count_q <= FORCE_VAL;
        else if (inc_now)         count_q <= count_q + CNT_W'(1);
    end

    // Register the strobe and the gated event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_o <= 1'b0;
            tick_o <= 1'b0;
            wrap_o <= 1'b0;
        end else begin
            step_o <= inc_now;
            tick_o <= inc_now && evt_ok_i;
            wrap_o <= inc_now && evt_ok_i && at_top;
        end
    end

    assign count_o = count_q;

    // R3: a strobe always marks a +1 step of the count
    a_r3_step_is_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (count_q == $past(count_q) + CNT_W'(1)));

    // R3: a tick never appears without an increment
    a_r3_tick_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> step_o);

    // R4: a wrap pulse coincides with a tick and a zero count
    a_r4_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (tick_o && count_q == '0));

    // R6: a clear command always yields a zero count
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.zero_cnt |=> (count_q == '0));

    // R5: the force-wrap command loads the near-wrap value
    a_r5_force_value: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.load_high |=> (count_q == FORCE_VAL));

    // R10: without a step or command the count holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ctl_i.zero_cnt && !ctl_i.load_high) |=> $stable(count_q));

endmodule

// File: rtl/lf_tick_counter.sv
// Module: prescaled low-frequency tick counter (top).
// Connects command resolution, the reload divider and the count core.
// Assumes every input is synchronous to the low-frequency clock clk.
module lf_tick_counter
    import lftc_pkg::*;
#(
    parameter int CNT_W          = 24,
    parameter int DIV_W          = 12,
    parameter int NEAR_WRAP_DIST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clear_i,
    input  logic             force_wrap_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             step_o,
    output logic             tick_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] FORCE_VAL = {CNT_W{1'b1}} - CNT_W'(NEAR_WRAP_DIST - 1);

    lftc_ctl_t ctl;
    logic      run;
    logic      evt_ok;
    logic      step_raw;

    lftc_task_ctl u_task_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .clear_i      (clear_i),
        .force_wrap_i (force_wrap_i),
        .ctl_o        (ctl),
        .run_o        (run),
        .evt_ok_o     (evt_ok)
    );

    lftc_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .reload_i    (ctl.reload),
        .div_wr_i    (div_wr_i),
        .div_wdata_i (div_wdata_i),
        .step_o      (step_raw)
    );

    lftc_count_core #(.CNT_W(CNT_W), .FORCE_VAL(FORCE_VAL)) u_count_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl),
        .step_i   (step_raw),
        .evt_ok_i (evt_ok),
        .count_o  (count_o),
        .step_o   (step_o),
        .tick_o   (tick_o),
        .wrap_o   (wrap_o)
    );

    // R8: no event pulse follows a cycle with stop asserted
    a_r8_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!tick_o && !wrap_o));

endmodule

// File: tb/test_lf_tick_counter.sv
// Bench: scoreboard. Driver tasks push expected per-cycle output items into
// a queue; a monitor pops items at their cycle stamp and compares.
module test_lf_tick_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0, force_wrap_i = 1'b0;
    logic        div_wr_i = 1'b0;
    logic [11:0] div_wdata_i = '0;
    logic [23:0] count_o;
    logic        step_o, tick_o, wrap_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [23:0] cnt;
        bit          tk;
        bit          inc;
        bit          wr;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;

    lf_tick_counter i_lf_tick_counter (
        .clk (clk), .rst_n (rst_n),
        .start_i (start_i), .stop_i (stop_i), .clear_i (clear_i),
        .force_wrap_i (force_wrap_i),
        .div_wr_i (div_wr_i), .div_wdata_i (div_wdata_i),
        .count_o (count_o), .step_o (step_o), .tick_o (tick_o), .wrap_o (wrap_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs against the item stamped for this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].at <= cyc) begin
                e = q.pop_front();
                checks++;
                if (e.at < cyc) begin
                    errors++;
                    $display("FAIL %s: item for cycle %0d missed at cycle %0d", e.tag, e.at, cyc);
                end else if (count_o !== e.cnt || tick_o !== e.tk || step_o !== e.inc || wrap_o !== e.wr) begin
                    errors++;
                    $display("FAIL %s @%0d: count=%h tick=%b step=%b wrap=%b expected count=%h tick=%b step=%b wrap=%b",
                             e.tag, cyc, count_o, tick_o, step_o, wrap_o, e.cnt, e.tk, e.inc, e.wr);
                end
            end
        end
    end

    task automatic expect_at(input int k, input logic [23:0] cnt, input bit tk,
                             input bit inc, input bit wr, input string tag);
        exp_t it;
        it.at = cyc + k; it.cnt = cnt; it.tk = tk; it.inc = inc; it.wr = wr; it.tag = tag;
        q.push_back(it);
    endtask

    // Running window: increment every d+1 cycles counted from the last reload.
    task automatic expect_run(input logic [23:0] base, input int d, input int n, input string tag);
        for (int j = 1; j <= n; j++) begin
            logic [23:0] c;
            bit          t;
            c = base + 24'(j / (d + 1));
            t = (j % (d + 1)) == 0;
            expect_at(j, c, t, t, t && (c == 24'h0), (t && c == 24'h0) ? {tag, " R4 wrap"} : tag);
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_hold(input logic [23:0] cnt, input int n, input string tag);
        for (int j = 1; j <= n; j++) expect_at(j, cnt, 1'b0, 1'b0, 1'b0, tag);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(input bit st, input bit sp, input bit cl, input bit fw);
        start_i = st; stop_i = sp; clear_i = cl; force_wrap_i = fw;
        @(negedge clk);
        start_i = 0; stop_i = 0; clear_i = 0; force_wrap_i = 0;
    endtask

    task automatic wr_div(input logic [11:0] v);
        div_wr_i = 1'b1; div_wdata_i = v;
        @(negedge clk);
        div_wr_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        expect_hold(24'h0, 4, "R1 reset idle");
        // R1/R2/R3: start with reset divider of 0 -> one step per cycle
        do_cmd(1, 0, 0, 0);
        expect_run(24'h0, 0, 6, "R2 R3 div0 run");
        // R7: write while running is ignored (rate stays one per cycle)
        wr_div(12'd7);
        expect_run(24'd7, 0, 4, "R7 write ignored while running");
        // R8: stop on an increment cycle -> final step, no tick
        expect_at(1, 24'd12, 0, 1, 0, "R8 final step on stop");
        do_cmd(0, 1, 0, 0);
        expect_hold(24'd12, 4, "R8 R10 stopped hold");
        // R7/R2: write while stopped, start with divider 2
        wr_div(12'd2);
        do_cmd(1, 0, 0, 0);
        expect_run(24'd12, 2, 9, "R2 R7 div2 spacing");
        // R5: force-wrap while running, then R4 wrap at divider 2
        expect_at(1, 24'hFFFFF0, 0, 0, 0, "R5 force value");
        do_cmd(0, 0, 0, 1);
        expect_run(24'hFFFFF0, 2, 48, "R2 R5 to wrap");
        expect_run(24'h0, 2, 3, "R4 after wrap");
        // R6: clear beats force-wrap, divider restarts
        expect_at(1, 24'h0, 0, 0, 0, "R6 clear beats force");
        do_cmd(0, 0, 1, 1);
        expect_run(24'h0, 2, 6, "R6 restart after clear");
        // R9: start and stop together while running -> stopped
        expect_at(1, 24'd2, 0, 0, 0, "R9 collide running");
        do_cmd(1, 1, 0, 0);
        expect_hold(24'd2, 5, "R9 stop wins running");
        // R9: start and stop together while stopped -> stays stopped
        expect_at(1, 24'd2, 0, 0, 0, "R9 collide stopped");
        do_cmd(1, 1, 0, 0);
        expect_hold(24'd2, 4, "R9 stop wins stopped");
        // R8 boundary: stop on the roll-over edge
        wr_div(12'd0);
        expect_at(1, 24'hFFFFF0, 0, 0, 0, "R5 force while stopped");
        do_cmd(0, 0, 0, 1);
        expect_hold(24'hFFFFF0, 2, "R10 hold after force");
        expect_at(1, 24'hFFFFF0, 0, 0, 0, "R2 start edge no step");
        do_cmd(1, 0, 0, 0);
        expect_run(24'hFFFFF0, 0, 15, "R2 walk to top");
        expect_at(1, 24'h0, 0, 1, 0, "R8 wrap silenced by stop");
        do_cmd(0, 1, 0, 0);
        expect_hold(24'h0, 3, "R8 hold after silent wrap");
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule